// File: doc/BRIEF.md
# Residue Channel Modular Multiplier for Moduli Near a Power of Two

This block is one lane of a residue-number datapath. On each cycle it can take two n-bit operands and a valid strobe. It forms their 2n-bit product and reduces that product modulo a channel modulus m = 2^n − c, where c is a small constant set by a parameter. The result leaves the block fully reduced, with a valid flag, two clock cycles after the operands arrive. A new operation can enter on every cycle.

The reduction uses no divider and no Barrett multipliers. Because 2^n is congruent to c modulo m, the upper half of the product is multiplied by the small constant c and added back to the lower half. The few bits of that fold that lie above position n are folded a second time. That second fold is a shift plus, when c is one more than a power of two, a plain copy of a short value. Four operands then pass through a carry-save adder. One resolving add follows, and at most two subtractions of m, chosen by comparison, bring the sum into range.

Top module: `mmChanMul`

## Requirements
- R1: When `inValid` is high, the `result` that belongs to that operation equals (opA × opB) mod (2^WIDTH − CONST), for any WIDTH-bit unsigned operands, including values at or above the modulus such as all ones.
- R2: Whenever `outValid` is high, `result` is strictly less than 2^WIDTH − CONST.
- R3: `outValid` is high on the cycle exactly two rising edges after a cycle in which `inValid` was high.
- R4: Operations may be presented on consecutive cycles with no gap, and each produces its own correct result on consecutive cycles.
- R5: `outValid` is never high unless `inValid` was high two cycles earlier.
- R6: While `outValid` is low, `result` keeps the value of the most recent completed operation. Operand values that are presented with `inValid` low have no effect on it.
- R7: While `rstN` is low, and on the first cycle after it is released, `outValid` is 0 and `result` is 0.
- R8: Corner operands reduce exactly: (m−1)×(m−1) gives 1, zero times any operand gives 0, and one times x gives x mod m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on opA/opB are to be multiplied this cycle |
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| outValid | output | 1 | result holds a new product this cycle |
| result | output | WIDTH | Product reduced modulo 2^WIDTH − CONST |

## Verification
The assertions assume that `inValid` is always a known 0 or 1. They check a product against the operands sampled two edges earlier, so they assume nothing about operand range. The reduction is argued for any n-bit pair, and the stimulus therefore includes values above the modulus, such as all ones. The assertions also take CONST to be small enough that 3c + c² stays below 2^n, which keeps the correction to at most two subtractions. The bench uses only the default parameters, which meet that condition. Its random operands are full WIDTH-bit values, and the idle cycles between bursts carry random operand values, so any leak from an unstrobed operand would show up.

// File: rtl/mmChanPkg.sv
package mmChanPkg;
  typedef struct packed {
    logic loadProd;
    logic loadRes;
  } chanStrobes_t;
endpackage

// File: rtl/mmCsa4.sv
module mmCsa4 #(
  parameter int W = 68
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  input  logic [W-1:0] inD,
  output logic [W-1:0] sumV,
  output logic [W-1:0] carV
);
  logic [W-1:0] s1, c1;
  always_comb begin
    s1   = inA ^ inB ^ inC;
    c1   = ((inA & inB) | (inA & inC) | (inB & inC)) << 1;
    sumV = s1 ^ c1 ^ inD;
    carV = ((s1 & c1) | (s1 & inD) | (c1 & inD)) << 1;
  end
endmodule

// File: rtl/mmChanCtrl.sv
module mmChanCtrl
  import mmChanPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output chanStrobes_t strobes,
  output logic         outValid
);
  logic stage1Valid, stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobes.loadProd = inValid;
    strobes.loadRes  = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/mmChanDatapath.sv
module mmChanDatapath
  import mmChanPkg::*;
#(
  parameter int WIDTH = 66,
  parameter int CONST = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobes_t     strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result
);
  localparam int CW   = $clog2(CONST + 1);
  localparam int K    = CW - 1;
  localparam int REST = CONST - (1 << K);
  localparam int SW   = WIDTH + 2;
  localparam int PW   = 2 * WIDTH;
  localparam int FW   = WIDTH + CW;
  localparam logic [SW-1:0] MODV = (SW'(1) << WIDTH) - SW'(CONST);
  localparam logic [SW-1:0] MOD2 = MODV << 1;

  logic [PW-1:0]    prodQ;
  logic [WIDTH-1:0] resQ;
  logic [FW-1:0]    fold1;
  logic [CW-1:0]    fold1Hi;
  logic [SW-1:0]    termLo, termFoldLo, termShift, termRest;
  logic [SW-1:0]    csaSum, csaCar, total, subV;
  logic [WIDTH-1:0] resNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prodQ <= '0;
    else if (strobes.loadProd) prodQ <= PW'(opA) * PW'(opB);
  end

  // first fold: upper half times the constant
  always_comb begin
    fold1   = FW'(prodQ[PW-1:WIDTH]) * FW'(CONST);
    fold1Hi = fold1[FW-1:WIDTH];
    termLo     = SW'(prodQ[WIDTH-1:0]);
    termFoldLo = SW'(fold1[WIDTH-1:0]);
    termShift  = SW'(fold1Hi) << K;
  end

  // second fold: fold1Hi*CONST split as a shift plus a remainder term
  generate
    if (REST == 0) begin : gRestNone
      assign termRest = '0;
    end else if (REST == 1) begin : gRestCopy
      assign termRest = SW'(fold1Hi);
    end else begin : gRestMul
      assign termRest = SW'(fold1Hi) * SW'(REST);
    end
  endgenerate

  mmCsa4 #(.W(SW)) uCsa (
    .inA (termLo),
    .inB (termFoldLo),
    .inC (termShift),
    .inD (termRest),
    .sumV(csaSum),
    .carV(csaCar)
  );

  always_comb begin
    total = csaSum + csaCar;
    if (total >= MOD2)      subV = MOD2;
    else if (total >= MODV) subV = MODV;
    else                    subV = '0;
    resNext = WIDTH'(total - subV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resQ <= '0;
    else if (strobes.loadRes) resQ <= resNext;
  end

  assign result = resQ;
endmodule

// File: rtl/mmChanMul.sv
module mmChanMul
  import mmChanPkg::*;
#(
  parameter int WIDTH = 66,
  parameter int CONST = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             outValid,
  output logic [WIDTH-1:0] result
);
  chanStrobes_t strobes;

  mmChanCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  mmChanDatapath #(.WIDTH(WIDTH), .CONST(CONST)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: rtl/mmChanMulChk.sv
module mmChanMulChk #(
  parameter int WIDTH = 66,
  parameter int CONST = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             outValid,
  input logic [WIDTH-1:0] result
);
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] MODW = (PW'(1) << WIDTH) - PW'(CONST);

  function automatic logic [WIDTH-1:0] refMod(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    logic [PW-1:0] p;
    p = PW'(x) * PW'(y);
    return WIDTH'(p % MODW);
  endfunction

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> result == refMod($past(opA, 2), $past(opB, 2))); // R1
  AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> PW'(result) < MODW); // R2
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2)); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result)); // R6
endmodule

bind mmChanMul mmChanMulChk #(.WIDTH(WIDTH), .CONST(CONST)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opA     (opA),
  .opB     (opB),
  .outValid(outValid),
  .result  (result)
);

// File: tb/tb_mmChanMul.sv
module tb_mmChanMul;
  localparam int WIDTH = 66;
  localparam int CONST = 5;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] MODW = (PW'(1) << WIDTH) - PW'(CONST);
  localparam logic [WIDTH-1:0] MODM1 = WIDTH'(MODW - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [WIDTH-1:0] opA = '0, opB = '0;
  logic outValid;
  logic [WIDTH-1:0] result;

  int nTests = 0, nFails = 0;
  bit done = 1'b0;

  logic pV1 = 1'b0, pV2 = 1'b0;
  logic [WIDTH-1:0] pE1 = '0, pE2 = '0, lastRes = '0;
  string pTag1 = "R1", pTag2 = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  mmChanMul #(.WIDTH(WIDTH), .CONST(CONST)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result)
  );

  function automatic logic [WIDTH-1:0] expMul(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    logic [PW-1:0] p;
    p = PW'(x) * PW'(y);
    return WIDTH'(p % MODW);
  endfunction

  function automatic logic [WIDTH-1:0] rnd();
    return WIDTH'({$urandom, $urandom, $urandom});
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: called at a negedge; checks the op issued two calls earlier, then drives a new one
  task automatic step(input logic v, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input string tag);
    if (pV2) begin
      check("R3", WIDTH'(outValid), WIDTH'(1'b1));
      check(pTag2, result, pE2);
      check("R2", WIDTH'(PW'(result) < MODW), WIDTH'(1'b1));
      lastRes = pE2;
    end else begin
      check("R5", WIDTH'(outValid), WIDTH'(1'b0));
      check("R6", result, lastRes);
    end
    inValid = v; opA = a; opB = b;
    pV2 = pV1; pE2 = pE1; pTag2 = pTag1;
    pV1 = v; pE1 = expMul(a, b); pTag1 = tag;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    check("R7", WIDTH'(outValid), WIDTH'(1'b0));
    check("R7", result, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7", WIDTH'(outValid), WIDTH'(1'b0));
    check("R7", result, '0);
    // directed corners, back to back
    step(1'b1, MODM1, MODM1, "R8");
    step(1'b1, '0, rnd(), "R8");
    step(1'b1, WIDTH'(1), MODM1, "R8");
    step(1'b1, '1, '1, "R1");
    step(1'b1, WIDTH'(1), '1, "R8");
    step(1'b1, WIDTH'(MODW), rnd(), "R1");
    step(1'b1, {1'b1, {(WIDTH-1){1'b0}}}, '1, "R1");
    // idle cycles with junk operands must not disturb result
    for (int i = 0; i < 4; i++) step(1'b0, rnd(), rnd(), "R6");
    // random bursts with gaps; R4 covered by consecutive strobes
    for (int i = 0; i < 600; i++) begin
      logic [WIDTH-1:0] a, b;
      a = rnd(); b = rnd();
      if (($urandom % 8) == 0) a = a | {4'hF, {(WIDTH-4){1'b0}}};
      if (($urandom % 8) == 0) b = MODM1 - WIDTH'($urandom % 4);
      step(($urandom % 4) != 0, a, b, "R4");
    end
    for (int i = 0; i < 3; i++) step(1'b0, rnd(), rnd(), "R6");
    done = 1'b1;
    finishRun();
  end
endmodule